// File: doc/BRIEF.md
# Pause-Free Collector Root Snapshot Engine

This block gathers the root set for a concurrent garbage collector without ever holding up the mutator. It holds the mutator's pointer stack in a two-port RAM and a small bank of mutator pointer registers. A one-cycle start pulse freezes a logical snapshot. The register values are copied into shadow registers. A scan pointer then walks the stack downwards on the RAM's second port while the mutator keeps pushing and popping on the first port. The mutator can remove at most one entry per cycle and the scan reads one slot per cycle, so the scan always stays below any slot the mutator can rewrite. No copy of the stack is made.

Roots leave on a single output with a valid flag, one per cycle. Stack entries come first, from the top of the snapshot down to slot 0, and then the shadow registers in index order. Null pointers (value 0) are suppressed. A one-cycle done flag marks the final root. The controller is a four-state machine: IDLE, STACK (scanning the stack), SHADOW (emitting shadow registers) and FINISH (done). Its transitions are: IDLE to STACK on an accepted start when the snapshot stack is non-empty; IDLE to SHADOW on an accepted start when it is empty; STACK to SHADOW after slot 0 is read; SHADOW to FINISH after the last register is emitted; FINISH to IDLE unconditionally.

Top module: `root_snap_engine`

## Requirements
- R1: After reset, root_vld_o and done_o are 0, stack_cnt_o is 0, pop_data_o is 0 and every mutator register reads 0.
- R2: pop_data_o shows the top stack entry, or 0 when the stack is empty. Pop removes the top entry and is ignored on an empty stack. Push appends an entry and is ignored on a full stack. When push and pop are both asserted, only the pop takes effect. stack_cnt_o never exceeds DEPTH.
- R3: A register write stores reg_wr_data_i into register reg_wr_sel_i at the clock edge. reg_rd_data_o shows the register selected by reg_rd_sel_i.
- R4: A start pulse accepted in IDLE (cycle P) snapshots the stack as it stands after the mutator operation of cycle P. Its entries are presented on root_o from the top down to slot 0, one per cycle. The first is presented in cycle P+2.
- R5: Pushes, pops and register writes made in any cycle after P do not change the values emitted, and the mutator is never stalled.
- R6: After the stack entries, register 0 up to register NREG-1 are presented one per cycle. Each carries its value at the start of cycle P+1, so a write in cycle P+1 is not seen.
- R7: A root whose value is 0 is presented with root_vld_o low. root_vld_o is never high with root_o equal to 0.
- R8: done_o is high for exactly one cycle, P+T+NREG+1, where T is the number of snapshot stack entries. This is the cycle in which the last register root is presented.
- R9: A start pulse arriving while a snapshot is in progress, including the done cycle, is ignored.
- R10: With an empty snapshot stack, register 0 is presented in cycle P+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle collection start pulse |
| push_i | input | 1 | Mutator push request |
| push_data_i | input | PW | Pointer to push |
| pop_i | input | 1 | Mutator pop request |
| pop_data_o | output | PW | Current top stack entry (0 if empty) |
| stack_cnt_o | output | $clog2(DEPTH+1) | Number of stack entries |
| reg_wr_i | input | 1 | Mutator register write enable |
| reg_wr_sel_i | input | SW | Register index to write |
| reg_wr_data_i | input | PW | Register write value |
| reg_rd_sel_i | input | SW | Register index to read |
| reg_rd_data_o | output | PW | Selected register value |
| root_o | output | PW | Root pointer |
| root_vld_o | output | 1 | Root valid (non-null) |
| done_o | output | 1 | Snapshot complete, one cycle |

## Verification
Stack roots appear two cycles after the pulse cycle, because the scan pointer loads at the pulse edge and the RAM data is registered at the next edge. The register roots follow directly after the last stack root, and done_o coincides with the final one. The bench model turns each accepted pulse into a queue of per-cycle expectations, with one empty entry for cycle P+1. It pops one entry at every rising edge and compares outputs on the falling edge, so each root, flag and done value is checked in exactly the cycle it is due. Mutator stack and register results are due in the cycle after their edge, and they are compared on every falling edge against the model's stack queue and register array.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STACK  = 2'd1,
        ST_SHADOW = 2'd2,
        ST_FINISH = 2'd3
    } snap_state_t;
endpackage

// File: rtl/rs_stack_ram.sv
module rs_stack_ram #(
    parameter int DEPTH = 16,
    parameter int PW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic [AW-1:0] a_addr,
    output logic [PW-1:0] a_data,
    input  logic [AW-1:0] b_addr,
    output logic [PW-1:0] b_data
);
    logic [PW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // port A serves the mutator, port B the snapshot scan
    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];
endmodule

// File: rtl/rs_stack_ctl.sv
module rs_stack_ctl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] top_addr,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] next_cnt
);
    logic do_push, do_pop;

    assign do_pop   = pop && (cnt != '0);
    assign do_push  = push && !pop && (cnt != CW'(DEPTH));
    assign next_cnt = cnt + CW'(do_push) - CW'(do_pop);
    assign we       = do_push;
    assign waddr    = cnt[AW-1:0];
    assign top_addr = AW'(cnt - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= next_cnt;
    end
endmodule

// File: rtl/rs_reg_bank.sv
module rs_reg_bank #(
    parameter int NREG = 2,
    parameter int PW   = 8,
    localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SW-1:0]      wr_sel,
    input  logic [PW-1:0]      wr_data,
    input  logic               cap,
    input  logic [SW-1:0]      rd_sel,
    output logic [PW-1:0]      rd_data,
    input  logic [SW-1:0]      emit_sel,
    input  logic               emit_live,
    output logic [PW-1:0]      emit_data,
    output logic [NREG*PW-1:0] live_flat,
    output logic [NREG*PW-1:0] shadow_flat
);
    logic [PW-1:0] live_r   [NREG];
    logic [PW-1:0] shadow_r [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_r[g]   <= '0;
                shadow_r[g] <= '0;
            end else begin
                if (wr_en && wr_sel == SW'(g)) live_r[g] <= wr_data;
                // shadow takes the value held before any same-cycle write
                if (cap) shadow_r[g] <= live_r[g];
            end
        end
        assign live_flat[g*PW +: PW]   = live_r[g];
        assign shadow_flat[g*PW +: PW] = shadow_r[g];
    end

    always_comb begin
        rd_data   = '0;
        emit_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_sel == SW'(i))   rd_data   = live_r[i];
            if (emit_sel == SW'(i)) emit_data = emit_live ? live_r[i] : shadow_r[i];
        end
    end
endmodule

// File: rtl/root_snap_engine.sv
module root_snap_engine
    import rs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 8,
    parameter int NREG  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          push_i,
    input  logic [PW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [PW-1:0] pop_data_o,
    output logic [CW-1:0] stack_cnt_o,
    input  logic          reg_wr_i,
    input  logic [SW-1:0] reg_wr_sel_i,
    input  logic [PW-1:0] reg_wr_data_i,
    input  logic [SW-1:0] reg_rd_sel_i,
    output logic [PW-1:0] reg_rd_data_o,
    output logic [PW-1:0] root_o,
    output logic          root_vld_o,
    output logic          done_o
);
    snap_state_t state_q, state_d;

    logic          we;
    logic [AW-1:0] waddr, top_addr;
    logic [CW-1:0] cnt, next_cnt;
    logic [PW-1:0] a_data, b_data, emit_data;
    logic [AW-1:0] scan_q;
    logic [SW-1:0] idx_q;
    logic          cap_q;
    logic          accept;
    logic [NREG*PW-1:0] live_flat, shadow_flat;

    rs_stack_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk(clk), .rst_n(rst_n), .push(push_i), .pop(pop_i),
        .we(we), .waddr(waddr), .top_addr(top_addr),
        .cnt(cnt), .next_cnt(next_cnt)
    );

    rs_stack_ram #(.DEPTH(DEPTH), .PW(PW)) u_ram (
        .clk(clk), .we(we), .waddr(waddr), .wdata(push_data_i),
        .a_addr(top_addr), .a_data(a_data),
        .b_addr(scan_q), .b_data(b_data)
    );

    rs_reg_bank #(.NREG(NREG), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_i), .wr_sel(reg_wr_sel_i), .wr_data(reg_wr_data_i),
        .cap(cap_q), .rd_sel(reg_rd_sel_i), .rd_data(reg_rd_data_o),
        .emit_sel(idx_q), .emit_live(cap_q), .emit_data(emit_data),
        .live_flat(live_flat), .shadow_flat(shadow_flat)
    );

    assign pop_data_o  = (cnt != '0) ? a_data : '0;
    assign stack_cnt_o = cnt;
    assign accept      = (state_q == ST_IDLE) && start_i;
    assign done_o      = (state_q == ST_FINISH);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = (next_cnt != '0) ? ST_STACK : ST_SHADOW;
            ST_STACK:  if (scan_q == '0) state_d = ST_SHADOW;
            ST_SHADOW: if (idx_q == SW'(NREG - 1)) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // scan pointer, register index and root output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q     <= '0;
            idx_q      <= '0;
            cap_q      <= 1'b0;
            root_o     <= '0;
            root_vld_o <= 1'b0;
        end else begin
            cap_q      <= accept;
            root_vld_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        scan_q <= AW'(next_cnt - CW'(1));
                        idx_q  <= '0;
                    end
                end
                ST_STACK: begin
                    root_o     <= b_data;
                    root_vld_o <= (b_data != '0);
                    scan_q     <= scan_q - AW'(1);
                end
                ST_SHADOW: begin
                    root_o     <= emit_data;
                    root_vld_o <= (emit_data != '0);
                    idx_q      <= idx_q + SW'(1);
                end
                ST_FINISH: ;
            endcase
        end
    end
endmodule

// File: rtl/rs_snap_chk.sv
module rs_snap_chk
    import rs_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = 8,
    parameter int NREG  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pop_i,
    input logic [CW-1:0]      stack_cnt_o,
    input logic [PW-1:0]      root_o,
    input logic               root_vld_o,
    input logic               done_o,
    input snap_state_t        state_q,
    input logic [AW-1:0]      scan_q,
    input logic               cap_q,
    input logic [NREG*PW-1:0] live_flat,
    input logic [NREG*PW-1:0] shadow_flat
);
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_cnt_o <= CW'(DEPTH));

    // R2
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_cnt_o == '0 && pop_i) |=> stack_cnt_o == '0);

    // R4
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STACK && scan_q != '0) |=> (scan_q == $past(scan_q) - AW'(1)));

    // R6
    stack_then_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STACK && scan_q == '0) |=> state_q == ST_SHADOW);

    // R6
    shadow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q |=> shadow_flat == $past(live_flat));

    // R7
    null_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        root_vld_o |-> root_o != '0);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !root_vld_o));

    // R9
    finish_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> state_q == ST_IDLE);
endmodule

bind root_snap_engine rs_snap_chk #(.DEPTH(DEPTH), .PW(PW), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .pop_i(pop_i), .stack_cnt_o(stack_cnt_o),
    .root_o(root_o), .root_vld_o(root_vld_o), .done_o(done_o),
    .state_q(state_q), .scan_q(scan_q), .cap_q(cap_q),
    .live_flat(live_flat), .shadow_flat(shadow_flat)
);

// File: tb/sim_root_snap_engine.sv
module sim_root_snap_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int PW    = 8;
    localparam int NREG  = 2;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int SW    = (NREG > 1) ? $clog2(NREG) : 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, push_i = 1'b0, pop_i = 1'b0, reg_wr_i = 1'b0;
    logic [PW-1:0] push_data_i = '0, reg_wr_data_i = '0;
    logic [SW-1:0] reg_wr_sel_i = '0, reg_rd_sel_i = '0;
    logic [PW-1:0] pop_data_o, reg_rd_data_o, root_o;
    logic [CW-1:0] stack_cnt_o;
    logic          root_vld_o, done_o;

    root_snap_engine #(.DEPTH(DEPTH), .PW(PW), .NREG(NREG)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    typedef struct { bit v; int d; bit dn; } exp_t;
    int   stk[$];
    int   mreg[NREG];
    exp_t expq[$];

    task automatic chk(string req, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    // reference model: updated at each rising edge out of reset
    always @(posedge clk) begin
        bit busy;
        cyc++;
        if (!rst_n) begin
            stk.delete();
            expq.delete();
            for (int i = 0; i < NREG; i++) mreg[i] = 0;
        end else begin
            busy = (expq.size() > 0);
            if (busy) void'(expq.pop_front());
            if (pop_i) begin
                if (stk.size() > 0) void'(stk.pop_back());
            end else if (push_i && stk.size() < DEPTH) begin
                stk.push_back(int'(push_data_i));
            end
            if (reg_wr_i) mreg[reg_wr_sel_i] = int'(reg_wr_data_i);
            if (!busy && start_i) begin
                exp_t e;
                e = '{0, 0, 0};
                expq.push_back(e);
                for (int k = stk.size() - 1; k >= 0; k--) begin
                    e = '{stk[k] != 0, stk[k], 0};
                    expq.push_back(e);
                end
                for (int j = 0; j < NREG; j++) begin
                    e = '{mreg[j] != 0, mreg[j], j == NREG - 1};
                    expq.push_back(e);
                end
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            e = (expq.size() > 0) ? expq[0] : '{0, 0, 0};
            chk("R4 R7 R9 R10 root_vld", int'(root_vld_o), int'(e.v));
            if (e.v) chk("R4 R5 R6 R10 root", int'(root_o), e.d);
            chk("R8 R9 done", int'(done_o), int'(e.dn));
            chk("R2 pop_data", int'(pop_data_o), (stk.size() > 0) ? stk[$] : 0);
            chk("R2 stack_cnt", int'(stack_cnt_o), stk.size());
            chk("R3 reg_rd", int'(reg_rd_data_o), mreg[reg_rd_sel_i]);
        end
    end

    task automatic step(bit st, bit pu, int pd, bit po, bit rw, int rs, int rd);
        @(posedge clk);
        #1;
        start_i       = st;
        push_i        = pu;
        push_data_i   = PW'(pd);
        pop_i         = po;
        reg_wr_i      = rw;
        reg_wr_sel_i  = SW'(rs);
        reg_wr_data_i = PW'(rd);
        reg_rd_sel_i  = SW'(rs);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=%0d exp=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 root_vld", int'(root_vld_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 stack_cnt", int'(stack_cnt_o), 0);
        chk("R1 pop_data", int'(pop_data_o), 0);
        chk("R1 reg_rd", int'(reg_rd_data_o), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: pop on empty, then fill with a null entry included
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 1, 8'h11, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0);
        step(0, 1, 8'h33, 0, 0, 0, 0);
        step(0, 1, 8'h44, 1, 0, 0, 0);          // R2 push+pop: pop only
        step(0, 1, 8'h55, 0, 1, 0, 8'h21);      // R3 write reg0
        step(0, 0, 0, 0, 1, 1, 8'h00);          // reg1 stays null (R7)

        // R4: start with a push in the pulse cycle (included in snapshot)
        step(1, 1, 8'h66, 0, 0, 0, 0);
        // R6: write in cycle P+1 not seen; R5: pop during scan
        step(0, 0, 0, 1, 1, 0, 8'h99);
        step(1, 0, 0, 1, 0, 0, 0);              // R9 start ignored
        step(0, 1, 8'h77, 0, 0, 1, 0);
        step(1, 1, 8'h78, 0, 1, 1, 8'h5a);      // R9 again
        idle(12);

        // R10: empty snapshot stack
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 8'h3c);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);              // R9 start in done cycle
        idle(6);

        // R2: overfill, then R5: snapshot a full stack with a pop every cycle
        for (int i = 0; i < DEPTH + 3; i++) step(0, 1, i + 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 4; i++) step(0, (i % 3) == 2, 8'hc0 + i, (i % 3) != 2, 0, 0, 0);
        idle(8);

        // mixed traffic with periodic starts
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            step(r == 0, r >= 8, (($urandom % 4) == 0) ? 0 : int'($urandom % 256),
                 r >= 2 && r < 7, r == 1 || r == 7, int'($urandom % NREG),
                 (($urandom % 3) == 0) ? 0 : int'($urandom % 256));
        end
        idle(DEPTH + NREG + 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule